// File: doc/BRIEF.md
# Decode-Stage Register Interlock Scoreboard

This block decides, once per cycle, whether the instruction sitting in the decode stage of a five-step in-order pipeline may move on to operand fetch. The later stages are operand fetch, execute and output save. The block keeps its own shadow copy of the pending writes held by those three later stages. Each entry is either a destination register or, for a store, a destination memory address. When the instruction in decode reads something that an older in-flight instruction will still write, the block raises `stall`.

There is no forwarding and no early release. A producer blocks its consumers for as long as it occupies operand fetch, execute or output save. The consumer advances in the cycle after the producer has left output save.

An instruction leaves decode on a clock edge where `dec_valid` is high and `stall` is low. At that edge its pending write, if it has one, enters the operand-fetch slot of the shadow. The later stages never hold, so every shadow entry moves one stage on at each edge. A stalled or empty decode slot inserts a bubble. The per-stage `flush` bits remove a wrong-path entry: a flushed entry stops counting as a producer in that same cycle and never comes back.

Top module: `decode_interlock`

## Requirements
- R1: After reset no entry is pending, so any decode instruction sees `stall` low until something issues.
- R2: While `dec_valid` is low, `stall` is low regardless of the other decode inputs.
- R3: An add (`dec_op` 0) stalls while any live pending register write targets `dec_src_a` or `dec_src_b`. It then writes register `dec_dst`.
- R4: An add-immediate (`dec_op` 1) compares only `dec_src_a`, and its `dec_src_b` field is ignored. It writes register `dec_dst`.
- R5: A load (`dec_op` 2) stalls only while a live pending store targets the same `dec_addr`. Its register source fields are ignored. It writes register `dec_dst`.
- R6: A store (`dec_op` 3) compares only `dec_src_a` against pending register writes. It writes memory address `dec_addr`.
- R7: A branch (`dec_op` 5) compares only `dec_src_a` and writes nothing. A jump (`dec_op` 4) never stalls and writes nothing.
- R8: An instruction issued at edge t is a producer during the three cycles that follow edge t (operand fetch, execute, output save). A dependent instruction directly behind it stalls for exactly three cycles and issues at the fourth edge. Dependency chains repeat this.
- R9: `flush` bit 0, 1 or 2 (operand fetch, execute, output save) removes that stage's entry as a producer in the same cycle, and the entry stays removed afterwards.
- R10: A stalled or invalid decode slot, and the spare op codes 6 and 7, never create a pending entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_op | input | 3 | Instruction class of the decode slot |
| dec_src_a | input | REG_W | First source register |
| dec_src_b | input | REG_W | Second source register |
| dec_dst | input | REG_W | Destination register |
| dec_addr | input | ADDR_W | Memory address for a load or store |
| flush | input | 3 | Per-stage flush: bit 0 operand fetch, 1 execute, 2 output save |
| stall | output | 1 | Decode must hold this cycle |

## Verification
The assertions assume that the decode inputs are stable between clock edges. They also assume that `flush` is applied only to a stage the surrounding pipeline really discards. Neither the assertions nor the bench expect any back-pressure from the later stages, because those stages always advance. The bench drives every input half a period away from the active edge and keeps `flush` low except in the flush scenario. Because of that, the reference model in the random stream only needs to shift its entries at every edge.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_ADDI   = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_JUMP   = 3'd4,
    OP_BRANCH = 3'd5
  } op_e;

  typedef struct packed {
    logic use_a;
    logic use_b;
    logic rd_mem;
    logic wr_reg;
    logic wr_mem;
  } opinfo_t;

  function automatic opinfo_t classify(input logic [2:0] op);
    opinfo_t r;
    r = '0;
    case (op)
      OP_ADD:    begin r.use_a = 1'b1; r.use_b = 1'b1; r.wr_reg = 1'b1; end
      OP_ADDI:   begin r.use_a = 1'b1; r.wr_reg = 1'b1; end
      OP_LOAD:   begin r.rd_mem = 1'b1; r.wr_reg = 1'b1; end
      OP_STORE:  begin r.use_a = 1'b1; r.wr_mem = 1'b1; end
      OP_BRANCH: begin r.use_a = 1'b1; end
      default:   r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sb_pending.sv
module sb_pending #(
  parameter int DEPTH = 3,
  parameter int ID_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       push_mem,
  input  logic [ID_W-1:0]            push_id,
  input  logic [DEPTH-1:0]           flush,
  output logic [DEPTH-1:0]           live,
  output logic [DEPTH-1:0]           is_mem,
  output logic [DEPTH-1:0][ID_W-1:0] ids
);
  logic [DEPTH-1:0] vld;

  assign live = vld & ~flush;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) vld[0] <= 1'b0;
        else        vld[0] <= push;
        is_mem[0] <= push_mem;
        ids[0]    <= push_id;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) vld[k] <= 1'b0;
        else        vld[k] <= live[k-1];
        is_mem[k] <= is_mem[k-1];
        ids[k]    <= ids[k-1];
      end
    end
  end

  // R10: nothing pushed means an empty operand-fetch slot next cycle
  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> !live[0]);
  // R9: a flushed operand-fetch entry never reaches execute
  p_flush_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush[0] |=> !vld[1]);
  // R8: a live entry advances one stage per edge
  p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
    live[0] |=> vld[1]);
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int DEPTH  = 3,
  parameter int ID_W   = 8,
  parameter int REG_W  = 4,
  parameter int ADDR_W = 8
) (
  input  sb_pkg::opinfo_t            info,
  input  logic [REG_W-1:0]           src_a,
  input  logic [REG_W-1:0]           src_b,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DEPTH-1:0]           live,
  input  logic [DEPTH-1:0]           is_mem,
  input  logic [DEPTH-1:0][ID_W-1:0] ids,
  output logic                       conflict
);
  logic [DEPTH-1:0] hit_a, hit_b, hit_m;

  for (genvar k = 0; k < DEPTH; k++) begin : g_cmp
    assign hit_a[k] = live[k] & ~is_mem[k] & (ids[k] == ID_W'(src_a));
    assign hit_b[k] = live[k] & ~is_mem[k] & (ids[k] == ID_W'(src_b));
    assign hit_m[k] = live[k] &  is_mem[k] & (ids[k] == ID_W'(addr));
  end

  assign conflict = (info.use_a  & (|hit_a))
                  | (info.use_b  & (|hit_b))
                  | (info.rd_mem & (|hit_m));
endmodule

// File: rtl/decode_interlock.sv
module decode_interlock #(
  parameter int REG_W  = 4,
  parameter int ADDR_W = 8,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [2:0]        dec_op,
  input  logic [REG_W-1:0]  dec_src_a,
  input  logic [REG_W-1:0]  dec_src_b,
  input  logic [REG_W-1:0]  dec_dst,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [STAGES-1:0] flush,
  output logic              stall
);
  localparam int ID_W = (REG_W > ADDR_W) ? REG_W : ADDR_W;

  sb_pkg::opinfo_t                info;
  logic                           conflict, push;
  logic [ID_W-1:0]                push_id;
  logic [STAGES-1:0]              live, is_mem;
  logic [STAGES-1:0][ID_W-1:0]    ids;

  assign info    = sb_pkg::classify(dec_op);
  assign stall   = dec_valid & conflict;
  assign push    = dec_valid & ~conflict & (info.wr_reg | info.wr_mem);
  assign push_id = info.wr_mem ? ID_W'(dec_addr) : ID_W'(dec_dst);

  sb_pending #(.DEPTH(STAGES), .ID_W(ID_W)) u_pending (
    .clk(clk), .rst_n(rst_n), .push(push), .push_mem(info.wr_mem),
    .push_id(push_id), .flush(flush), .live(live), .is_mem(is_mem), .ids(ids)
  );

  sb_hazard #(.DEPTH(STAGES), .ID_W(ID_W), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_hazard (
    .info(info), .src_a(dec_src_a), .src_b(dec_src_b), .addr(dec_addr),
    .live(live), .is_mem(is_mem), .ids(ids), .conflict(conflict)
  );

  // R2: empty decode slot never stalls
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !stall);
  // R7: jumps never wait on data
  p_jump_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_op == 3'd4) |-> !stall);
  // R8: a stall always has a live producer behind it
  p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (|live));
  // R1: the first cycle out of reset has nothing pending
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !stall);
endmodule

// File: tb/test_decode_interlock.sv
module test_decode_interlock;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, dec_valid = 1'b0;
  logic [2:0] dec_op = '0;
  logic [REG_W-1:0] dec_src_a = '0, dec_src_b = '0, dec_dst = '0;
  logic [ADDR_W-1:0] dec_addr = '0;
  logic [2:0] flush = '0;
  logic stall;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decode_interlock #(.REG_W(REG_W), .ADDR_W(ADDR_W), .STAGES(3)) i_decode_interlock (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .dec_addr(dec_addr), .flush(flush), .stall(stall)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (stall !== exp) begin
      failures++;
      $display("FAIL %s: stall=%0b expected=%0b at %0t", req, stall, exp, $time);
    end
  endtask

  // drive decode for one cycle, then sample away from the edge
  task automatic step(input bit v, input logic [2:0] op, input int a, input int b,
                      input int d, input int ad, input logic exp, input string req,
                      input logic [2:0] fl = 3'b000);
    @(negedge clk);
    dec_valid = v; dec_op = op; dec_src_a = REG_W'(a); dec_src_b = REG_W'(b);
    dec_dst = REG_W'(d); dec_addr = ADDR_W'(ad); flush = fl;
    #1 check(exp, req);
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, 0, 0, 0, 1'b0, "R2");
  endtask

  task automatic t_reset();
    step(1, 3'd0, 1, 2, 3, 0, 1'b0, "R1");
    drain();
  endtask

  task automatic t_idle();
    step(1, 3'd0, 0, 0, 5, 0, 1'b0, "R3");
    step(0, 3'd0, 5, 5, 0, 0, 1'b0, "R2");
    drain();
  endtask

  task automatic t_chain();
    step(1, 3'd0, 0, 0, 3, 0, 1'b0, "R3");
    for (int i = 0; i < 3; i++) step(1, 3'd0, 1, 3, 4, 0, 1'b1, "R8");
    step(1, 3'd0, 1, 3, 4, 0, 1'b0, "R8");
    for (int i = 0; i < 3; i++) step(1, 3'd0, 4, 0, 6, 0, 1'b1, "R3");
    step(1, 3'd0, 4, 0, 6, 0, 1'b0, "R8");
    drain();
  endtask

  task automatic t_addi();
    step(1, 3'd0, 0, 0, 6, 0, 1'b0, "R4");
    step(1, 3'd1, 1, 6, 9, 0, 1'b0, "R4");
    step(1, 3'd1, 6, 0, 9, 0, 1'b1, "R4");
    step(1, 3'd1, 6, 0, 9, 0, 1'b1, "R4");
    step(1, 3'd1, 6, 0, 9, 0, 1'b0, "R4");
    drain();
  endtask

  task automatic t_load();
    step(1, 3'd0, 0, 0, 9, 0, 1'b0, "R5");
    step(1, 3'd3, 1, 0, 0, 'h40, 1'b0, "R6");
    step(1, 3'd2, 9, 9, 10, 'h41, 1'b0, "R5");
    step(1, 3'd2, 0, 0, 11, 'h40, 1'b1, "R5");
    step(1, 3'd2, 0, 0, 11, 'h40, 1'b1, "R5");
    step(1, 3'd2, 0, 0, 11, 'h40, 1'b0, "R5");
    drain();
  endtask

  task automatic t_store();
    step(1, 3'd0, 0, 0, 11, 0, 1'b0, "R6");
    step(1, 3'd3, 5, 11, 0, 'h40, 1'b0, "R6");
    step(1, 3'd3, 11, 0, 0, 'h40, 1'b1, "R6");
    step(1, 3'd3, 11, 0, 0, 'h40, 1'b1, "R6");
    step(1, 3'd3, 11, 0, 0, 'h40, 1'b0, "R6");
    // a store writes memory, not a register: reading register 0 is free
    step(1, 3'd0, 0, 0, 1, 'h40, 1'b0, "R6");
    drain();
  endtask

  task automatic t_branch_jump();
    step(1, 3'd0, 0, 0, 12, 0, 1'b0, "R7");
    step(1, 3'd4, 12, 12, 12, 0, 1'b0, "R7");
    step(1, 3'd5, 0, 12, 12, 0, 1'b0, "R7");
    step(1, 3'd5, 12, 0, 0, 0, 1'b1, "R7");
    step(1, 3'd5, 12, 0, 0, 0, 1'b0, "R7");
    drain();
  endtask

  task automatic t_flush();
    step(1, 3'd0, 0, 0, 13, 0, 1'b0, "R9");
    step(1, 3'd0, 13, 0, 14, 0, 1'b0, "R9", 3'b001);
    step(1, 3'd0, 13, 0, 1, 0, 1'b0, "R9");
    drain();
    step(1, 3'd0, 0, 0, 15, 0, 1'b0, "R9");
    step(0, 3'd0, 0, 0, 0, 0, 1'b0, "R9");
    step(0, 3'd0, 0, 0, 0, 0, 1'b0, "R9");
    step(1, 3'd0, 15, 0, 2, 0, 1'b1, "R9");
    step(1, 3'd0, 15, 0, 2, 0, 1'b0, "R9", 3'b100);
    drain();
  endtask

  task automatic t_bubble();
    step(1, 3'd6, 0, 0, 1, 0, 1'b0, "R10");
    step(1, 3'd0, 1, 1, 2, 0, 1'b0, "R10");
    drain();
    step(1, 3'd0, 0, 0, 3, 0, 1'b0, "R10");
    step(1, 3'd0, 3, 0, 5, 0, 1'b1, "R10");
    step(1, 3'd0, 5, 5, 7, 0, 1'b0, "R10");
    drain();
  endtask

  // random stream against a small model written from R3..R8
  task automatic t_random();
    bit mv[3]; bit mm[3]; int mid[3];
    for (int k = 0; k < 3; k++) begin mv[k] = 0; mm[k] = 0; mid[k] = 0; end
    for (int n = 0; n < 400; n++) begin
      int op, a, b, d, ad;
      bit v, ua, ub, rm, wr, wm, exp;
      v = ($urandom % 5) != 0; op = $urandom % 8;
      a = $urandom % 4; b = $urandom % 4; d = $urandom % 4; ad = $urandom % 4;
      ua = (op == 0 || op == 1 || op == 3 || op == 5);
      ub = (op == 0); rm = (op == 2);
      wr = (op <= 2); wm = (op == 3);
      exp = 0;
      for (int k = 0; k < 3; k++) begin
        if (mv[k] && !mm[k] && ((ua && mid[k] == a) || (ub && mid[k] == b))) exp = v;
        if (mv[k] && mm[k] && rm && mid[k] == ad) exp = v;
      end
      step(v, 3'(op), a, b, d, ad, exp, "R8 random");
      for (int k = 2; k > 0; k--) begin mv[k] = mv[k-1]; mm[k] = mm[k-1]; mid[k] = mid[k-1]; end
      mv[0] = v && !exp && (wr || wm); mm[0] = wm; mid[0] = wm ? ad : d;
    end
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check(1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    t_reset(); t_idle(); t_chain(); t_addi(); t_load(); t_store();
    t_branch_jump(); t_flush(); t_bubble(); t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule